// File: doc/BRIEF.md
# Condition Code and Branch Unit

This block keeps the processor status word of a 16-bit load/store processor and decides each cycle where the program counter goes next. It looks at the value being written back, sorts it as negative, zero or positive, and stores that class as a one-hot three-bit flag code in the low bits of the status word. Bit 15 of the same word holds the privilege level. Only trap entry and return-from-trap may load it.

A conditional branch names the flags it wants in instruction bits 11:9. The unit takes the branch when any named flag is set in the stored code. It then steers the next PC to the supplied target. Trap and return also steer the PC to the target. Every other instruction moves on to PC plus one.

The unit handles one instruction per clock and has no flow control. All pins are plain control and status signals, sampled on every rising edge while reset is released. Instruction decode outside the condition field, the ALU, the register file and memory belong to neighbouring blocks.

Top module: `cc_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no write, `psr` reads 16'h8002: privilege 1 and flags at the zero code.
- R2: On a flag update, bits 2:0 of `psr` take 3'b100 if `wb_result[15]` is 1, 3'b010 if `wb_result` is zero, and 3'b001 otherwise. Exactly one of the three bits is set at all times.
- R3: The flags update on the rising edge of any cycle in which `rf_we`, `trap_en` or `rti_en` is high. In every other cycle they hold their value, whatever `wb_result` carries.
- R4: `psr[15]` loads `new_priv` on the edge of a cycle with `trap_en` or `rti_en` high. In every other cycle, including cycles with `rf_we` high, `new_priv` has no effect and the bit holds.
- R5: `psr[14:3]` always reads zero.
- R6: `br_taken` = `br_en` AND (OR over i of `insn[9+i]` AND `psr[i]`), with `psr[2]`=N, `psr[1]`=Z and `psr[0]`=P. A field of 3'b000 never branches, 3'b111 always branches, and the other instruction bits are ignored.
- R7: `next_pc` is `br_target` when `trap_en` or `rti_en` is high. Otherwise it is `br_target` when `br_taken` is high. Otherwise it is `pc`+1 modulo 2^16, so 16'hFFFF wraps to 16'h0000.
- R8: Flags written on one edge decide a branch presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wb_result | input | 16 | Value being written back this cycle |
| rf_we | input | 1 | Register-file write in this cycle |
| trap_en | input | 1 | Trap entry in this cycle |
| rti_en | input | 1 | Return from trap in this cycle |
| new_priv | input | 1 | Privilege level loaded by trap or return |
| insn | input | 16 | Current instruction; bits 11:9 are the condition field |
| br_en | input | 1 | Current instruction is a conditional branch |
| pc | input | 16 | Current program counter |
| br_target | input | 16 | Target for a branch, trap or return |
| next_pc | output | 16 | Program counter for the next instruction |
| br_taken | output | 1 | Conditional branch is taken |
| psr | output | 16 | Status word: privilege at bit 15, flags at bits 2:0 |

## Verification
The bench checks how results are sorted at the edges. 16'h8000 and 16'hFFFF must read as negative, 16'h7FFF and 16'h0001 as positive, and zero as zero. A design that tests the wrong bit, or compares unsigned, would store the positive code for these negatives. The bench also checks that a cycle with no write leaves the flags alone, and that a plain register write leaves the privilege bit alone. A design with a loose enable would show a change in `psr` one cycle later.

For branches, the bench drives the all-clear and all-set condition fields and a disabled branch. It sets unrelated instruction bits to ones, and it wraps the PC at 16'hFFFF. A design that reads the wrong field, or omits the increment wrap or the trap override, would show the wrong `next_pc` or `br_taken`.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned FLAG_W   = 3;
  localparam int unsigned COND_LSB = 9;
  localparam int unsigned PRIV_BIT = WORD_W - 1;
  localparam int unsigned PAD_W    = PRIV_BIT - FLAG_W;

  typedef logic [FLAG_W-1:0] flags_t;

  localparam flags_t FLAG_NEG  = 3'b100;
  localparam flags_t FLAG_ZERO = 3'b010;
  localparam flags_t FLAG_POS  = 3'b001;

  localparam logic RESET_PRIV = 1'b1;
endpackage

// File: rtl/ccb_classifier.sv
module ccb_classifier
  import ccb_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] value,
  output flags_t       cls
);
  always_comb begin
    if (value[W-1])
      cls = FLAG_NEG;
    else if (value == '0)
      cls = FLAG_ZERO;
    else
      cls = FLAG_POS;
  end
endmodule

// File: rtl/ccb_status_reg.sv
module ccb_status_reg
  import ccb_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_we,
  input  flags_t       flag_d,
  input  logic         priv_we,
  input  logic         priv_d,
  output logic [W-1:0] word
);
  localparam int unsigned PAD = W - 1 - FLAG_W;

  flags_t flag_q;
  logic   priv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= FLAG_ZERO;
      priv_q <= RESET_PRIV;
    end else begin
      if (flag_we) flag_q <= flag_d;
      if (priv_we) priv_q <= priv_d;
    end
  end

  assign word = {priv_q, {PAD{1'b0}}, flag_q};
endmodule

// File: rtl/ccb_branch_test.sv
module ccb_branch_test
  import ccb_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] insn,
  input  logic         enable,
  input  flags_t       flags,
  output logic         taken
);
  flags_t want;
  flags_t hit;

  assign want = insn[COND_LSB +: FLAG_W];

  for (genvar i = 0; i < FLAG_W; i++) begin : g_hit
    assign hit[i] = want[i] & flags[i];
  end

  assign taken = enable & (|hit);
endmodule

// File: rtl/ccb_pc_select.sv
module ccb_pc_select #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] target,
  input  logic         force_jump,
  input  logic         taken,
  output logic [W-1:0] next_pc
);
  logic [W-1:0] seq_pc;

  assign seq_pc = pc + W'(1);

  always_comb begin
    if (force_jump)
      next_pc = target;
    else if (taken)
      next_pc = target;
    else
      next_pc = seq_pc;
  end
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import ccb_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wb_result,
  input  logic         rf_we,
  input  logic         trap_en,
  input  logic         rti_en,
  input  logic         new_priv,
  input  logic [W-1:0] insn,
  input  logic         br_en,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] br_target,
  output logic [W-1:0] next_pc,
  output logic         br_taken,
  output logic [W-1:0] psr
);
  flags_t cls;
  logic   priv_write;
  logic   flag_write;

  assign priv_write = trap_en | rti_en;
  assign flag_write = rf_we | priv_write;

  ccb_classifier #(.W(W)) u_cls (
    .value (wb_result),
    .cls   (cls)
  );

  ccb_status_reg #(.W(W)) u_psr (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_we (flag_write),
    .flag_d  (cls),
    .priv_we (priv_write),
    .priv_d  (new_priv),
    .word    (psr)
  );

  ccb_branch_test #(.W(W)) u_brt (
    .insn   (insn),
    .enable (br_en),
    .flags  (psr[FLAG_W-1:0]),
    .taken  (br_taken)
  );

  ccb_pc_select #(.W(W)) u_pcs (
    .pc         (pc),
    .target     (br_target),
    .force_jump (priv_write),
    .taken      (br_taken),
    .next_pc    (next_pc)
  );
endmodule

// File: rtl/ccb_checker.sv
module ccb_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rf_we,
  input logic         trap_en,
  input logic         rti_en,
  input logic         new_priv,
  input logic [W-1:0] insn,
  input logic [W-1:0] pc,
  input logic [W-1:0] next_pc,
  input logic         br_taken,
  input logic [W-1:0] psr
);
  // R5
  psr_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psr[W-2:3] == '0);

  // R2
  nzp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(psr[2:0]) == 1);

  // R3
  nzp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we || trap_en || rti_en) |=> $stable(psr[2:0]));

  // R4
  priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_en || rti_en) |=> $stable(psr[W-1]));

  // R4
  priv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_en || rti_en) |=> psr[W-1] == $past(new_priv));

  // R6
  never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn[11:9] == 3'b000 |-> !br_taken);

  // R7
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_en || rti_en || br_taken) |-> next_pc == pc + W'(1));
endmodule

bind cc_branch_unit ccb_checker #(.W(W)) u_ccb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .rf_we    (rf_we),
  .trap_en  (trap_en),
  .rti_en   (rti_en),
  .new_priv (new_priv),
  .insn     (insn),
  .pc       (pc),
  .next_pc  (next_pc),
  .br_taken (br_taken),
  .psr      (psr)
);

// File: tb/test_cc_branch_unit.sv
module test_cc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wb_result = '0;
  logic        rf_we = 1'b0, trap_en = 1'b0, rti_en = 1'b0, new_priv = 1'b0;
  logic [15:0] insn = '0;
  logic        br_en = 1'b0;
  logic [15:0] pc = '0, br_target = '0;
  logic [15:0] next_pc, psr;
  logic        br_taken;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cc_branch_unit i_cc_branch_unit (
    .clk(clk), .rst_n(rst_n), .wb_result(wb_result), .rf_we(rf_we),
    .trap_en(trap_en), .rti_en(rti_en), .new_priv(new_priv), .insn(insn),
    .br_en(br_en), .pc(pc), .br_target(br_target),
    .next_pc(next_pc), .br_taken(br_taken), .psr(psr)
  );

  // Row: we trap rti npriv | result | cond | pc | target | psr after edge
  localparam int NV = 10;
  localparam logic [70:0] VEC [NV] = '{
    {4'b1000, 16'h8000, 3'b010, 16'h0010, 16'h0100, 16'h8004}, // R2 neg edge
    {4'b0001, 16'h0005, 3'b100, 16'h0011, 16'h0200, 16'h8004}, // R3 hold, R4 ignored
    {4'b1000, 16'h0000, 3'b100, 16'h0012, 16'h0300, 16'h8002}, // R2 zero
    {4'b1000, 16'h7FFF, 3'b010, 16'h0013, 16'h0400, 16'h8001}, // R2 pos edge
    {4'b0100, 16'hFFFF, 3'b001, 16'h0014, 16'h0500, 16'h0004}, // R4 trap
    {4'b1001, 16'h0001, 3'b100, 16'h0015, 16'h0600, 16'h0001}, // R4 rf_we no priv
    {4'b0011, 16'h0000, 3'b110, 16'h0016, 16'h0700, 16'h8002}, // R4 rti
    {4'b1000, 16'hFFFF, 3'b011, 16'h0017, 16'h0800, 16'h8004}, // R8 next sees
    {4'b0000, 16'h0000, 3'b100, 16'h0018, 16'h0900, 16'h8004}, // R3 hold, R8
    {4'b0000, 16'h1234, 3'b011, 16'hFFFF, 16'h0A00, 16'h8004}  // R7 wrap
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_taken(input logic en, input logic [2:0] c,
                                       input logic [15:0] w);
    return en & ((c[2] & w[2]) | (c[1] & w[1]) | (c[0] & w[0]));
  endfunction

  task automatic idle();
    rf_we = 0; trap_en = 0; rti_en = 0; br_en = 0; new_priv = 0;
  endtask

  initial begin
    logic [15:0] mpsr;
    logic        et;
    logic [15:0] enp;
    repeat (3) @(negedge clk);
    check(psr == 16'h8002, "R1 reset", psr, 16'h8002);
    rst_n = 1'b1;
    @(negedge clk);
    check(psr == 16'h8002, "R1 after release", psr, 16'h8002);
    mpsr = 16'h8002;

    for (int i = 0; i < NV; i++) begin
      {rf_we, trap_en, rti_en, new_priv} = VEC[i][70:67];
      wb_result = VEC[i][66:51];
      insn      = {4'hA, VEC[i][50:48], 9'h1FF};
      br_en     = 1'b1;
      pc        = VEC[i][47:32];
      br_target = VEC[i][31:16];
      #1;
      et  = model_taken(1'b1, VEC[i][50:48], mpsr);
      enp = (trap_en | rti_en | et) ? br_target : pc + 16'd1;
      check(br_taken == et, "R6/R8 taken", {15'b0, br_taken}, {15'b0, et});
      check(next_pc == enp, "R7 next_pc", next_pc, enp);
      @(negedge clk);
      mpsr = VEC[i][15:0];
      check(psr == mpsr, "R2/R3/R4/R5 psr", psr, mpsr);
    end
    idle();

    // R6: condition 000 never branches, flags at N
    insn = 16'hF1FF; br_en = 1; pc = 16'h0040; br_target = 16'h0999; #1;
    check(br_taken == 0, "R6 cond 000", {15'b0, br_taken}, 16'h0);
    check(next_pc == 16'h0041, "R7 no branch", next_pc, 16'h0041);
    // R6: 111 always branches
    insn = 16'h0E00; #1;
    check(br_taken == 1, "R6 cond 111", {15'b0, br_taken}, 16'h1);
    check(next_pc == 16'h0999, "R7 branch target", next_pc, 16'h0999);
    // R6: br_en low
    br_en = 0; #1;
    check(br_taken == 0, "R6 br_en low", {15'b0, br_taken}, 16'h0);
    check(next_pc == 16'h0041, "R7 not a branch", next_pc, 16'h0041);
    // R7: trap overrides with branch disabled
    trap_en = 1; new_priv = 1; wb_result = 16'h0001; #1;
    check(next_pc == 16'h0999, "R7 trap target", next_pc, 16'h0999);
    @(negedge clk); idle();
    check(psr == 16'h8001, "R4 trap priv 1", psr, 16'h8001);
    // R3: no write with nonzero result keeps P
    wb_result = 16'h8000; @(negedge clk);
    check(psr == 16'h8001, "R3 held", psr, 16'h8001);
    // R1: reset mid-run
    rst_n = 0; #1;
    check(psr == 16'h8002, "R1 async reset", psr, 16'h8002);
    @(negedge clk); rst_n = 1; @(negedge clk);
    check(psr == 16'h8002, "R1 reset value kept", psr, 16'h8002);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule